// File: doc/BRIEF.md
# Flash Array Write/Erase Controller

This block stands in front of a word-addressed nonvolatile store and decides which bus writes are allowed to change it. A small register bus (address, write strobe with write data, read strobe with registered read data) reaches three things: a main array made of equal pages, a separate small user-settings region, and a bank of control registers. A two-bit mode held in the control bank gates everything that can change the store. Mode 1 lets data writes program words. Mode 2 lets erase commands return words to all ones. Modes 0 and 3 leave the store read-only.

Programming follows flash rules: a write can only clear bits, so the stored word becomes the old word ANDed with the written word. Erase restores all ones. It can target one page through either of two page-erase registers, the whole main array, or only the user region. Every access completes in one bus cycle, and the ready flag always reads as set.

The address has two region-select bits on top. `00` selects the main array, where the low bits are the word index. `01` selects the user region, where the low bits are the word index. `10` selects the control bank, where the low three bits are the register offset. `11` is unmapped and reads as zero. The control offsets are: 0 = mode, 1 = ready, 2 = page erase A, 3 = page erase B, 4 = erase main array, 5 = erase user region. Offsets 6 and 7 are unused and read as zero.

Top module: `flc_top`

## Requirements
- R1: The mode register resets to 0. A write stores bits [1:0] of the write data, and a read returns exactly that value (0 to 3) with all upper bits zero.
- R2: Reading the ready register always returns 1 (bit 0 set, every other bit zero).
- R3: After reset every word of the main array and of the user region reads 0xFFFFFFFF.
- R4: In mode 1, a write to a main-array word stores the old word ANDed with the write data. A read in the next cycle returns that value.
- R5: Data writes to the main array or the user region while the mode is 0, 2 or 3 leave the stored words unchanged.
- R6: In mode 2, writing any word address to page erase A or page erase B sets every word of the page containing that address (address bits above the page-offset bits) to 0xFFFFFFFF. Every other page is left unchanged.
- R7: In mode 2, writing data with bit 0 set to the erase-main register sets every main-array word to 0xFFFFFFFF and leaves the user region unchanged.
- R8: In mode 2, writing data with bit 0 set to the erase-user register sets every user-region word to 0xFFFFFFFF and leaves the main array unchanged.
- R9: Erase commands are ignored when the mode is not 2. The erase-main and erase-user commands are also ignored when bit 0 of the data is 0.
- R10: `rdata` is 0 after reset. It is loaded only in a cycle where `rd_en` is high, with the value addressed in that cycle, and holds otherwise.
- R11: In mode 1, a write to a user-region word programs it with the same AND rule as the main array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (13) | Word address: region select in the top two bits, index or offset below |
| wr_en | input | 1 | Write strobe |
| wdata | input | DW (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DW (32) | Registered read data |

## Verification
A read's data is due on `rdata` at the first rising edge after the edge that samples `rd_en`. A write, program or erase takes effect at the edge that samples it, so a read issued in the very next cycle already sees the new contents. A mode change gates accesses from the following cycle on. Stimulus changes only on falling edges, and the behavioural model, which updates at the same rising edge as the design, is compared against `rdata` at every falling edge. The directed reads also sample one time unit after the rising edge that loads `rdata`.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {
    RGN_MAIN = 2'b00,
    RGN_USER = 2'b01,
    RGN_CTRL = 2'b10,
    RGN_NONE = 2'b11
  } flc_rgn_e;

  localparam logic [2:0] OFS_MODE   = 3'd0;
  localparam logic [2:0] OFS_READY  = 3'd1;
  localparam logic [2:0] OFS_ERPG_A = 3'd2;
  localparam logic [2:0] OFS_ERPG_B = 3'd3;
  localparam logic [2:0] OFS_ERALL  = 3'd4;
  localparam logic [2:0] OFS_ERUSR  = 3'd5;

  localparam logic [1:0] MODE_PROG  = 2'd1;
  localparam logic [1:0] MODE_ERASE = 2'd2;
endpackage

// File: rtl/flc_decode.sv
module flc_decode
  import flc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output flc_rgn_e          rgn,
  output logic [2:0]        ofs
);
  assign rgn = flc_rgn_e'(addr[ADDR_W-1 -: 2]);
  assign ofs = addr[2:0];
endmodule

// File: rtl/flc_store.sv
// Word store with flash semantics. Data words sit in a plain array with no
// reset (LUT-RAM style, asynchronous read); a per-word blank flag marks words
// that read as all ones, so any erase is a single-cycle flag update.
module flc_store #(
  parameter int DW         = 32,
  parameter int WORDS      = 2048,
  parameter int PAGE_WORDS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 prog_en,
  input  logic [AW-1:0]        prog_idx,
  input  logic [DW-1:0]        prog_data,
  input  logic                 erase_pg_en,
  input  logic [PGW-1:0]       erase_pg,
  input  logic                 erase_all_en,
  input  logic [AW-1:0]        rd_idx,
  output logic [DW-1:0]        rd_word
);
  localparam int AW  = $clog2(WORDS);
  localparam int PAW = $clog2(PAGE_WORDS);
  localparam int NPG = WORDS / PAGE_WORDS;
  localparam int PGW = (NPG > 1) ? $clog2(NPG) : 1;

  logic [DW-1:0]    mem [WORDS];
  logic [WORDS-1:0] blank;
  logic [NPG-1:0]   page_hit;
  logic [DW-1:0]    old_word;

  for (genvar p = 0; p < NPG; p++) begin : g_page
    assign page_hit[p] = erase_all_en || (erase_pg_en && (int'(erase_pg) == p));
  end

  assign old_word = blank[prog_idx] ? '1 : mem[prog_idx];

  always_ff @(posedge clk) begin
    if (prog_en) mem[prog_idx] <= old_word & prog_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blank <= '1;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (page_hit[w >> PAW])
          blank[w] <= 1'b1;
        else if (prog_en && (int'(prog_idx) == w))
          blank[w] <= 1'b0;
      end
    end
  end

  assign rd_word = blank[rd_idx] ? '1 : mem[rd_idx];
endmodule

// File: rtl/flc_top.sv
module flc_top
  import flc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int PAGE_WORDS = 8,
  parameter int PAGES      = 256,
  parameter int UCFG_WORDS = 64,
  localparam int MAIN_WORDS = PAGE_WORDS * PAGES,
  localparam int MAIN_AW    = $clog2(MAIN_WORDS),
  localparam int ADDR_W     = MAIN_AW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  input  logic              rd_en,
  output logic [DW-1:0]     rdata
);
  localparam int UCFG_AW = $clog2(UCFG_WORDS);
  localparam int PAW     = $clog2(PAGE_WORDS);
  localparam int PGW     = (PAGES > 1) ? $clog2(PAGES) : 1;

  flc_rgn_e      rgn;
  logic [2:0]    ofs;
  logic [1:0]    mode_q;
  logic          main_prog, user_prog;
  logic          erase_ok, erase_pg, erase_all, erase_usr, erase_any;
  logic [DW-1:0] main_word, user_word, ctrl_word, rd_next;

  flc_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .rgn(rgn), .ofs(ofs));

  assign main_prog = wr_en && (rgn == RGN_MAIN) && (mode_q == MODE_PROG);
  assign user_prog = wr_en && (rgn == RGN_USER) && (mode_q == MODE_PROG);
  assign erase_ok  = wr_en && (rgn == RGN_CTRL) && (mode_q == MODE_ERASE);
  assign erase_pg  = erase_ok && ((ofs == OFS_ERPG_A) || (ofs == OFS_ERPG_B));
  assign erase_all = erase_ok && (ofs == OFS_ERALL) && wdata[0];
  assign erase_usr = erase_ok && (ofs == OFS_ERUSR) && wdata[0];
  assign erase_any = erase_pg || erase_all || erase_usr;

  flc_store #(.DW(DW), .WORDS(MAIN_WORDS), .PAGE_WORDS(PAGE_WORDS)) u_main (
    .clk(clk), .rst(rst),
    .prog_en(main_prog), .prog_idx(addr[MAIN_AW-1:0]), .prog_data(wdata),
    .erase_pg_en(erase_pg), .erase_pg(wdata[PAW +: PGW]),
    .erase_all_en(erase_all),
    .rd_idx(addr[MAIN_AW-1:0]), .rd_word(main_word)
  );

  flc_store #(.DW(DW), .WORDS(UCFG_WORDS), .PAGE_WORDS(UCFG_WORDS)) u_user (
    .clk(clk), .rst(rst),
    .prog_en(user_prog), .prog_idx(addr[UCFG_AW-1:0]), .prog_data(wdata),
    .erase_pg_en(1'b0), .erase_pg(1'b0),
    .erase_all_en(erase_usr),
    .rd_idx(addr[UCFG_AW-1:0]), .rd_word(user_word)
  );

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= '0;
    else if (wr_en && (rgn == RGN_CTRL) && (ofs == OFS_MODE))
      mode_q <= wdata[1:0];
  end

  always_comb begin
    case (ofs)
      OFS_MODE:  ctrl_word = DW'(mode_q);
      OFS_READY: ctrl_word = DW'(1);
      default:   ctrl_word = '0;
    endcase
    case (rgn)
      RGN_MAIN: rd_next = main_word;
      RGN_USER: rd_next = user_word;
      RGN_CTRL: rd_next = ctrl_word;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/flc_chk.sv
module flc_chk #(
  parameter int ADDR_W = 13,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DW-1:0]     wdata,
  input logic              rd_en,
  input logic [DW-1:0]     rdata,
  input logic [1:0]        mode,
  input logic              main_prog,
  input logic              erase_any
);
  localparam logic [ADDR_W-1:0] A_MODE  = {2'b10, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] A_READY = A_MODE | ADDR_W'(1);

  a_r2_ready_one: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_READY) |=> (rdata == DW'(1)));

  a_r1_mode_echo: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && addr == A_MODE) ##1 (rd_en && !wr_en && addr == A_MODE)
    |=> (rdata == DW'($past(wdata[1:0], 2))));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  a_r5_prog_gated: assert property (@(posedge clk) disable iff (rst)
    main_prog |-> (mode == 2'd1));

  a_r9_erase_gated: assert property (@(posedge clk) disable iff (rst)
    erase_any |-> (mode == 2'd2));

  a_r4_bits_only_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && addr[ADDR_W-1 -: 2] == 2'b00 && mode == 2'd1)
    ##1 (rd_en && !wr_en && addr == $past(addr))
    |=> ((rdata & ~$past(wdata, 2)) == '0));
endmodule

bind flc_top flc_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rd_en(rd_en), .rdata(rdata), .mode(mode_q),
  .main_prog(main_prog), .erase_any(erase_any)
);

// File: tb/sim_flc_top.sv
`timescale 1ns/1ps
module sim_flc_top;
  localparam int DW = 32, AW = 13, MW = 2048, UW = 64, PW = 8;
  localparam logic [AW-1:0] USR = 13'h0800, CTL = 13'h1000;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R10";

  logic [31:0] m_main [MW];
  logic [31:0] m_user [UW];
  logic [1:0]  m_mode;
  logic [31:0] m_rd;

  always #4 clk = ~clk;

  flc_top u0 (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
              .wdata(wdata), .rd_en(rd_en), .rdata(rdata));

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    case (a[12:11])
      2'b00: return m_main[a[10:0]];
      2'b01: return m_user[a[5:0]];
      2'b10: case (a[2:0])
               3'd0: return {30'b0, m_mode};
               3'd1: return 32'd1;
               default: return 32'd0;
             endcase
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_write(logic [AW-1:0] a, logic [31:0] d);
    case (a[12:11])
      2'b00: if (m_mode == 2'd1) m_main[a[10:0]] &= d;
      2'b01: if (m_mode == 2'd1) m_user[a[5:0]] &= d;
      2'b10: case (a[2:0])
               3'd0: m_mode = d[1:0];
               3'd2, 3'd3: if (m_mode == 2'd2)
                 for (int k = 0; k < PW; k++) m_main[{d[10:3], 3'(k)}] = ONES;
               3'd4: if (m_mode == 2'd2 && d[0])
                 for (int k = 0; k < MW; k++) m_main[k] = ONES;
               3'd5: if (m_mode == 2'd2 && d[0])
                 for (int k = 0; k < UW; k++) m_user[k] = ONES;
               default: ;
             endcase
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 2'd0; m_rd = 32'd0;
      for (int k = 0; k < MW; k++) m_main[k] = ONES;
      for (int k = 0; k < UW; k++) m_user[k] = ONES;
    end else begin
      if (rd_en) m_rd = m_read(addr);
      if (wr_en) m_write(addr, wdata);
    end
  end

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Model comparison on every falling edge after reset has been applied once.
  always @(negedge clk) if (!done && $time > 20) check(rdata, m_rd, cur_req);

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1; rd_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk); addr = a; wr_en = 0; rd_en = 1;
  endtask

  task automatic idle();
    @(negedge clk); wr_en = 0; rd_en = 0;
  endtask

  task automatic rd_expect(logic [AW-1:0] a, logic [31:0] exp, string req);
    rd(a);
    @(posedge clk); #1;
    check(rdata, exp, req);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 / R3 / R2 / R1 reset state
    cur_req = "R10"; idle(); idle();
    cur_req = "R3";
    rd_expect(13'd0, ONES, "R3");
    rd_expect(13'd2047, ONES, "R3");
    rd_expect(USR | 13'd5, ONES, "R3");
    cur_req = "R2";  rd_expect(CTL | 13'd1, 32'd1, "R2");
    cur_req = "R1";  rd_expect(CTL, 32'd0, "R1");
    // R5: program while read-only
    cur_req = "R5";
    wr(13'd10, 32'h0);
    rd_expect(13'd10, ONES, "R5");
    // R1: mode echo including 3
    cur_req = "R1";
    wr(CTL, 32'hFFFF_FFF7);
    rd_expect(CTL, 32'd3, "R1");
    wr(13'd10, 32'h0);                // mode 3: ignored (R5)
    rd_expect(13'd10, ONES, "R5");
    wr(CTL, 32'd1);
    rd_expect(CTL, 32'd1, "R1");
    // R4: AND programming, back-to-back read
    cur_req = "R4";
    wr(13'd10, 32'h1234_5678);
    rd_expect(13'd10, 32'h1234_5678, "R4");
    wr(13'd10, 32'hFFFF_00FF);
    rd_expect(13'd10, 32'h1234_0078, "R4");
    wr(13'd17, 32'hA5A5_A5A5);
    wr(13'd2047, 32'h0000_FFFF);
    rd_expect(13'd2047, 32'h0000_FFFF, "R4");
    // R11: user region programming
    cur_req = "R11";
    wr(USR | 13'd5, 32'h0BAD_F00D);
    wr(USR | 13'd5, 32'hFFFF_0FFF);
    rd_expect(USR | 13'd5, 32'h0BAD_000D, "R11");
    // R9: erase in program mode ignored
    cur_req = "R9";
    wr(CTL | 13'd2, 32'd10);
    wr(CTL | 13'd4, 32'd1);
    rd_expect(13'd10, 32'h1234_0078, "R9");
    // R6: page erase via A, then via B
    wr(CTL, 32'd2);
    cur_req = "R5";
    wr(13'd17, 32'h0);                // erase mode: program ignored
    rd_expect(13'd17, 32'hA5A5_A5A5, "R5");
    cur_req = "R6";
    wr(CTL | 13'd2, 32'd13);          // page 1 (words 8..15)
    rd_expect(13'd10, ONES, "R6");
    rd_expect(13'd17, 32'hA5A5_A5A5, "R6");
    wr(CTL | 13'd3, 32'd16);          // page 2 via second register
    rd_expect(13'd17, ONES, "R6");
    rd_expect(13'd2047, 32'h0000_FFFF, "R6");
    // R9: erase-main with bit0 clear ignored
    cur_req = "R9";
    wr(CTL | 13'd4, 32'hFFFF_FFFE);
    rd_expect(13'd2047, 32'h0000_FFFF, "R9");
    // R7: erase main, user region kept
    cur_req = "R7";
    wr(CTL | 13'd4, 32'd1);
    rd_expect(13'd2047, ONES, "R7");
    rd_expect(USR | 13'd5, 32'h0BAD_000D, "R7");
    // R8: erase user, main kept
    cur_req = "R8";
    wr(CTL, 32'd1);
    wr(13'd40, 32'h5555_0000);
    wr(CTL, 32'd2);
    wr(CTL | 13'd5, 32'd1);
    rd_expect(USR | 13'd5, ONES, "R8");
    rd_expect(13'd40, 32'h5555_0000, "R8");
    // R10: rdata holds across idle cycles and writes
    cur_req = "R10";
    idle(); wr(CTL, 32'd1); idle(); idle();
    // R4 mixed traffic against the model
    cur_req = "R4";
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) wr({7'd0, lfsr[6:1]}, {lfsr, ~lfsr} | 32'h0101_0000);
      else if (lfsr[1]) rd({7'd0, lfsr[7:2]});
      else idle();
    end
    idle(); idle();
    finish_run();
  end
endmodule